// File: doc/BRIEF.md
# Write-Enable and Protection Status Register

This block keeps the status byte of a serial non-volatile memory and rules on every write that the serial front end wants to commit. The front end decodes each command and presents it for one clock cycle when chip select rises. With the command come a flag telling whether the transfer ended on a whole byte, the target address of an array write, and the data byte of a status write. The block answers one cycle later with a commit pulse or a reject pulse. After a commit it holds a busy indication for a fixed, parameterised number of cycles, which models the internal programming time.

The ruling combines four things. The first is a write-enable latch. The second is an external write-protect pin level, which protects only while it is low. The third is a protect-enable bit that arms that pin. The fourth is a pair of block-protect bits that fence off the upper part of the array. The latch clears itself after every committed write, so each write needs its own enable. The persistent bits are held in ordinary flops.

Top module: `wps_status_ctrl`

## Requirements
- R1: The status byte carries the protect-enable bit in bit 7, zeros in bits 6 to 4, the block-protect code in bits 3:2, the write-enable latch in bit 1 and the busy flag in bit 0. After reset the status byte is 8'h00 and no pulse is raised.
- R2: A latch-set command (kind 1) sets the latch and a latch-clear command (kind 2) clears it, whatever the protection state and whether or not the block is busy. Such a command takes effect only if it is byte aligned, and it produces neither a commit nor a reject pulse.
- R3: A write command (kind 3 status write, kind 4 array write) that arrives with the byte-aligned flag low is rejected, and it leaves bits 7 to 1 of the status byte unchanged.
- R4: While the latch is 0, every write command is rejected.
- R5: Hardware protection is active exactly when the pin is low and bit 7 is 1. While it is active a status write is rejected. It has no effect on array writes.
- R6: A committed status write loads bit 7 and bits 3:2 from the same positions of the data byte. The data bits 6:4, 1 and 0 are ignored.
- R7: The block-protect code guards the array by the top two address bits. Code 00 guards nothing, 01 guards the quarter where the top bits are 11, 10 guards the half where the top bit is 1, and 11 guards the whole array. An array write to a guarded address is rejected.
- R8: A commit clears the latch. A reject leaves the latch as it was.
- R9: After a commit, the busy output and status bit 0 are 1 for exactly WRITE_CYCLES cycles, starting the cycle after the command. Any write command that arrives while busy is 1 is rejected.
- R10: The commit and reject pulses last one cycle, appear in the cycle after the command, and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle strobe of a decoded command at chip-select rise |
| cmd_kind_i | input | 3 | 1 latch set, 2 latch clear, 3 status write, 4 array write, other values ignored |
| cmd_aligned_i | input | 1 | Transfer ended on a whole byte boundary |
| wr_addr_i | input | ADDR_W | Target address of an array write |
| wr_data_i | input | 8 | Data byte of a status write |
| wp_pin_i | input | 1 | Write-protect pin level, protecting while low |
| commit_o | output | 1 | Write committed (one-cycle pulse) |
| reject_o | output | 1 | Write refused (one-cycle pulse) |
| busy_o | output | 1 | Modelled write cycle in progress |
| status_o | output | 8 | Status byte for reads |

## Verification
The busy timer running out and a new write arriving can fall into the same cycle. The bench provokes this by issuing an array write in the very last busy cycle, with the latch already set again during the busy window. It expects a reject there, and a commit when the same write comes one cycle later. A latch-set command can also land during a write cycle or under hardware protection, and it must still take effect. The bench provokes this case too and judges the latch bit in the status byte. The rulings on whole writes are judged by a sweep over every combination of enable bit, pin, latch, protect code and address quadrant. The expected result of each is computed in the bench.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_LATCH_SET = 3'd1,
    CMD_LATCH_CLR = 3'd2,
    CMD_STAT_WR   = 3'd3,
    CMD_ARRAY_WR  = 3'd4
  } wps_cmd_e;

  localparam int SB_PEN  = 7;
  localparam int SB_BPH  = 3;
  localparam int SB_BPL  = 2;
  localparam int SB_LAT  = 1;
  localparam int SB_BUSY = 0;
endpackage

// File: rtl/wps_region_check.sv
module wps_region_check #(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] quad;
  assign quad = addr_i[TOP -: 2];

  always_comb begin
    unique case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = (quad == 2'b11);
      2'b10:   hit_o = quad[1];
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wps_busy_timer.sv
module wps_busy_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    if (start_i) cnt_d = LOAD;
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R9: a new write cycle is launched only from idle
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R9: busy is visible the cycle after a launch
  p_busy_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
endmodule

// File: rtl/wps_guard.sv
module wps_guard
  import wps_pkg::*;
(
  input  logic     valid_i,
  input  wps_cmd_e kind_i,
  input  logic     aligned_i,
  input  logic     busy_i,
  input  logic     latch_i,
  input  logic     pen_i,
  input  logic     wp_pin_i,
  input  logic     region_hit_i,
  output logic     commit_o,
  output logic     reject_o,
  output logic     lat_set_o,
  output logic     lat_clr_o
);
  logic is_write;
  logic hw_lock;
  logic target_ok;
  logic write_ok;

  always_comb begin
    is_write  = (kind_i == CMD_STAT_WR) || (kind_i == CMD_ARRAY_WR);
    hw_lock   = pen_i && !wp_pin_i;
    target_ok = (kind_i == CMD_STAT_WR) ? !hw_lock : !region_hit_i;
    write_ok  = aligned_i && !busy_i && latch_i && target_ok;
    commit_o  = valid_i && is_write && write_ok;
    reject_o  = valid_i && is_write && !write_ok;
    lat_set_o = valid_i && aligned_i && (kind_i == CMD_LATCH_SET);
    lat_clr_o = valid_i && aligned_i && (kind_i == CMD_LATCH_CLR);
  end
endmodule

// File: rtl/wps_status_ctrl.sv
module wps_status_ctrl
  import wps_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_kind_i,
  input  logic              cmd_aligned_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wp_pin_i,
  output logic              commit_o,
  output logic              reject_o,
  output logic              busy_o,
  output logic [7:0]        status_o
);
  wps_cmd_e   kind;
  logic       pen_q, pen_d;
  logic [1:0] bp_q, bp_d;
  logic       lat_q, lat_d;
  logic       commit_q, reject_q;
  logic       g_commit, g_reject, g_set, g_clr;
  logic       region_hit;
  logic       busy;
  logic       nv_en;
  logic       stat_commit;

  assign kind = wps_cmd_e'(cmd_kind_i);

  wps_region_check #(.ADDR_W(ADDR_W)) u_region (
    .bp_i   (bp_q),
    .addr_i (wr_addr_i),
    .hit_o  (region_hit)
  );

  wps_guard u_guard (
    .valid_i      (cmd_valid_i),
    .kind_i       (kind),
    .aligned_i    (cmd_aligned_i),
    .busy_i       (busy),
    .latch_i      (lat_q),
    .pen_i        (pen_q),
    .wp_pin_i     (wp_pin_i),
    .region_hit_i (region_hit),
    .commit_o     (g_commit),
    .reject_o     (g_reject),
    .lat_set_o    (g_set),
    .lat_clr_o    (g_clr)
  );

  wps_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (g_commit),
    .busy_o  (busy)
  );

  always_comb begin
    stat_commit = g_commit && (kind == CMD_STAT_WR);
    nv_en       = stat_commit;
    pen_d       = wr_data_i[SB_PEN];
    bp_d        = wr_data_i[SB_BPH:SB_BPL];
    if (g_commit)   lat_d = 1'b0;
    else if (g_set) lat_d = 1'b1;
    else if (g_clr) lat_d = 1'b0;
    else            lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q    <= 1'b0;
      bp_q     <= 2'b00;
      lat_q    <= 1'b0;
      commit_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      if (nv_en) begin
        pen_q <= pen_d;
        bp_q  <= bp_d;
      end
      lat_q    <= lat_d;
      commit_q <= g_commit;
      reject_q <= g_reject;
    end
  end

  assign commit_o = commit_q;
  assign reject_o = reject_q;
  assign busy_o   = busy;

  always_comb begin
    status_o          = 8'h00;
    status_o[SB_PEN]  = pen_q;
    status_o[SB_BPH:SB_BPL] = bp_q;
    status_o[SB_LAT]  = lat_q;
    status_o[SB_BUSY] = busy;
  end

  // R10: commit and reject never together
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && reject_o));
  // R4: no commit without the latch
  p_latch_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !lat_q) |=> !commit_o);
  // R5: hardware lock blocks status writes
  p_hw_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && kind == CMD_STAT_WR && pen_q && !wp_pin_i) |=> !commit_o);
  // R7: guarded array region is never written
  p_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && kind == CMD_ARRAY_WR && region_hit) |=> !commit_o);
  // R8: a commit leaves the latch cleared
  p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !lat_q);
  // R9: writes during busy are refused; a commit starts the busy window
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && busy) |=> !commit_o);
  p_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> busy_o);
  // R3: an unaligned command changes no stored bit
  p_unaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !cmd_aligned_i) |=> (!commit_o && $stable({pen_q, bp_q, lat_q})));
endmodule

// File: tb/wps_status_ctrl_bench.sv
`timescale 1ns/1ps
module wps_status_ctrl_bench;
  localparam int AW = 12;
  localparam int WC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_kind;
  logic          cmd_aligned;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          wp_pin;
  logic          commit, reject, busy;
  logic [7:0]    status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wps_status_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u_wps_status_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .cmd_aligned_i(cmd_aligned), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wp_pin_i(wp_pin), .commit_o(commit), .reject_o(reject), .busy_o(busy),
    .status_o(status)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic al, input logic [AW-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_kind = k; cmd_aligned = al; wr_addr = a; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 3'd0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic bit guarded(input logic [1:0] bp, input logic [1:0] q);
    return (bp == 2'b11) || (bp == 2'b10 && q[1]) || (bp == 2'b01 && q == 2'b11);
  endfunction

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_aligned = 1'b1;
    wr_addr = '0; wr_data = 8'h00; wp_pin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 8'h00);
    chk({commit, reject, busy} == 3'b000, "R1 reset pulses", {5'b0, commit, reject, busy}, 8'h00);

    // R9 busy window and same-cycle race with timer expiry
    issue(3'd1, 1'b1, '0, 8'h00);
    issue(3'd4, 1'b1, '0, 8'h00);
    chk(commit && !reject, "R10 commit pulse", {6'b0, commit, reject}, 8'h02);
    chk(status == 8'h01, "R8 latch cleared busy set", status, 8'h01);
    cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_aligned = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 3'd0;
    chk(!commit, "R10 commit one cycle", {7'b0, commit}, 8'h00);
    chk(status[1] == 1'b1, "R2 set during busy", status, 8'h03);
    repeat (WC - 2) @(negedge clk);
    chk(busy == 1'b1, "R9 busy in last cycle", {7'b0, busy}, 8'h01);
    cmd_valid = 1'b1; cmd_kind = 3'd4; wr_addr = '0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 3'd0;
    chk(reject && !commit, "R9 write in last busy cycle rejected", {6'b0, commit, reject}, 8'h01);
    chk(busy == 1'b0, "R9 busy ends after WRITE_CYCLES", {7'b0, busy}, 8'h00);
    chk(status == 8'h02, "R8 reject keeps latch", status, 8'h02);
    issue(3'd4, 1'b1, '0, 8'h00);
    chk(commit, "R9 write after busy commits", {7'b0, commit}, 8'h01);
    wait_idle();

    // latch commands under hardware lock; unaligned commands
    issue(3'd1, 1'b1, '0, 8'h00);
    issue(3'd3, 1'b1, '0, 8'h80);
    wait_idle();
    chk(status == 8'h80, "R6 enable bit written", status, 8'h80);
    wp_pin = 1'b0;
    issue(3'd1, 1'b1, '0, 8'h00);
    chk(status == 8'h82, "R2 set under hardware lock", status, 8'h82);
    issue(3'd3, 1'b1, '0, 8'h00);
    chk(reject && status == 8'h82, "R5 status write locked", status, 8'h82);
    issue(3'd2, 1'b1, '0, 8'h00);
    chk(status == 8'h80 && !commit && !reject, "R2 clear under lock", status, 8'h80);
    issue(3'd1, 1'b0, '0, 8'h00);
    chk(status == 8'h80, "R2 unaligned set ignored", status, 8'h80);
    wp_pin = 1'b1;
    issue(3'd1, 1'b1, '0, 8'h00);
    issue(3'd3, 1'b0, '0, 8'h0C);
    chk(reject && !commit, "R3 unaligned write rejected", {6'b0, commit, reject}, 8'h01);
    chk(status == 8'h82, "R3 unaligned write no change", status, 8'h82);
    issue(3'd4, 1'b0, '0, 8'h00);
    chk(reject && status == 8'h82, "R3 unaligned array write", status, 8'h82);

    // full sweep
    for (int pen = 0; pen < 2; pen++)
      for (int bp = 0; bp < 4; bp++)
        for (int wp = 0; wp < 2; wp++)
          for (int lat = 0; lat < 2; lat++)
            for (int t = 0; t < 5; t++) begin
              logic [7:0] base, exp_s, d;
              logic [1:0] q;
              bit ok, is_stat;
              string tag;
              wait_idle();
              wp_pin = 1'b1;
              issue(3'd1, 1'b1, '0, 8'h00);
              issue(3'd3, 1'b1, '0, {pen[0], 3'b000, bp[1:0], 2'b00});
              wait_idle();
              if (lat == 0) issue(3'd2, 1'b1, '0, 8'h00);
              else          issue(3'd1, 1'b1, '0, 8'h00);
              wp_pin = wp[0];
              is_stat = (t == 4);
              q = t[1:0];
              d = {~pen[0], 3'b111, ~bp[1:0], 2'b11};
              base = {pen[0], 3'b000, bp[1:0], lat[0], 1'b0};
              if (is_stat) ok = (lat == 1) && !(pen == 1 && wp == 0);
              else         ok = (lat == 1) && !guarded(bp[1:0], q);
              if (lat == 0)     tag = "R4";
              else if (is_stat) tag = "R5";
              else              tag = "R7";
              issue(is_stat ? 3'd3 : 3'd4, 1'b1, {q, 10'h155}, d);
              chk(commit == ok && reject == !ok, tag, {6'b0, commit, reject}, {6'b0, ok, !ok});
              if (!ok)          exp_s = base;
              else if (is_stat) exp_s = {d[7], 3'b000, d[3:2], 2'b01};
              else              exp_s = {pen[0], 3'b000, bp[1:0], 2'b01};
              chk(status == exp_s, ok ? (is_stat ? "R6" : "R8") : "R8 reject keeps state", status, exp_s);
            end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule